// File: doc/BRIEF.md
# Serial Control Port Slave

This block is a synchronous serial slave port. An external master supplies the serial clock and an active-low select line. The slave takes bits from a data-in line and can return bits on a data-out line that it drives only when it has something to send. Each transfer starts with a command byte that gives a direction bit and a register address. A sixteen-edge transfer carries a data byte after the command. A read returns the contents of a small stub register file, and a write updates it. The whole block is clocked by the serial clock only, so it works whether or not any system clock is running.

Releasing the select line ends any transfer at once and stops the data-out driver in the same instant. Holding the select line low with data-in high for a long stretch puts the block into a test mode that asks every device pin to float. An active-low open-drain interrupt request is modelled as a pull-down enable. It is active while any enabled event bit is pending, and reading the event register clears those bits.

Top module: `scp_slave`

## Requirements
- R1: After reset, the data-out enable, the float request and the interrupt pull-down are all 0, and every stub register reads back as 0.
- R2: The first byte of a frame is the command, sent MSB first and sampled on rising serial clock edges. Bit 7 set means read and clear means write. Bits 6..3 hold the register address, and bits 2..0 are ignored.
- R3: In a read, the addressed byte is shifted out MSB first. Bit k (k = 0 for the MSB) appears on data-out at the falling edge after rising edge 8+k of the frame. The data-out enable is 1 only after the falling edge that follows rising edge 8 of a read command, and only while select stays low.
- R4: When select goes high, the data-out enable drops to 0 at once, without waiting for a clock edge, and the frame in progress is abandoned.
- R5: A write takes effect only if select was low for exactly 16 rising edges. The data byte is stored at the first rising edge that sees select high. Frames of 8, 15 or 17 edges store nothing.
- R6: The float request rises after the 33rd consecutive rising edge with select low, provided data-in was high at every one of those edges. After 32 such edges it is still 0.
- R7: The float request drops at once when select goes high or data-in goes low. It does not return within the same low period of select, even if data-in goes high again.
- R8: The edge count saturates, so a low period of select lasting well over 33 edges with data-in held high keeps the float request asserted for the whole period.
- R9: Each 1 bit on the event input at a rising edge sets the matching pending bit in the event register at address 2. The interrupt pull-down is 1 whenever a pending bit is also set in the mask register at address 3.
- R10: Reading address 2 returns the pending bits and clears them at rising edge 8 of that frame. This releases the interrupt pull-down unless new events arrive.
- R11: Writes to address 2 have no effect on the pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk_i | input | 1 | Serial clock from the master |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scp_en_ni | input | 1 | Port select, active low |
| sdi_i | input | 1 | Serial data in |
| irq_src_i | input | 8 | Event bits, sampled on rising edges |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Data-out driver enable (0 = high impedance) |
| force_hiz_o | output | 1 | Request to float all device outputs |
| irq_pull_o | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
Several properties are checked on every rising edge. The float request is never seen before 33 edges of the current low period. The edge count never passes its ceiling. A low data-in bit with select low removes the float request by the next edge. The data-out enable never appears before the command byte is complete. Stored writes land at the written address, reading the event register empties it, and a write aimed at it leaves it untouched. Only the bench's scenarios can show that data comes back bit-exact, that frames of the wrong length write nothing, that an abort removes the driver in the same instant, and that the interrupt line follows the mask.

// File: rtl/scp_pkg.sv
package scp_pkg;
    // Direction bit of the command byte
    localparam logic DIR_WRITE = 1'b0;
    localparam logic DIR_READ  = 1'b1;
endpackage

// File: rtl/scp_frame.sv
module scp_frame
    import scp_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 4,
    parameter int HIZ_EDGES = 33,
    localparam int FW  = 2 * DW,
    localparam int SAT = HIZ_EDGES + 1,
    localparam int CW  = $clog2(SAT + 1)
) (
    input  logic          sclk_i,
    input  logic          rst_ni,
    input  logic          en_ni,
    input  logic          sdi_i,
    output logic [CW-1:0] cnt_o,
    output logic          rd_now_o,
    output logic [AW-1:0] raddr_o,
    output logic          commit_o,
    output logic [AW-1:0] waddr_o,
    output logic [DW-1:0] wdata_o,
    output logic          tx_step_o,
    output logic          force_hiz_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [FW-1:0] sh;
        logic          allhi;
        logic          test;
    } frame_s;

    frame_s        frame_d, frame_q;
    logic [DW-1:0] cmd_byte;

    always_comb begin
        frame_d = frame_q;
        if (en_ni) begin
            frame_d.cnt   = '0;
            frame_d.sh    = '0;
            frame_d.allhi = 1'b1;
            frame_d.test  = 1'b0;
        end else begin
            frame_d.cnt   = (frame_q.cnt == CW'(SAT)) ? frame_q.cnt : frame_q.cnt + 1'b1;
            frame_d.sh    = {frame_q.sh[FW-2:0], sdi_i};
            frame_d.allhi = frame_q.allhi & sdi_i;
            frame_d.test  = frame_d.allhi && (frame_d.cnt >= CW'(HIZ_EDGES));
        end
    end

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) frame_q <= '0;
        else         frame_q <= frame_d;
    end

    assign cmd_byte    = {frame_q.sh[DW-2:0], sdi_i};
    assign cnt_o       = frame_q.cnt;
    assign rd_now_o    = !en_ni && (frame_q.cnt == CW'(DW - 1)) && (cmd_byte[DW-1] == DIR_READ);
    assign raddr_o     = cmd_byte[DW-2 -: AW];
    assign commit_o    = en_ni && (frame_q.cnt == CW'(FW)) && (frame_q.sh[FW-1] == DIR_WRITE);
    assign waddr_o     = frame_q.sh[FW-2 -: AW];
    assign wdata_o     = frame_q.sh[DW-1:0];
    assign tx_step_o   = !en_ni && (frame_q.cnt >= CW'(DW)) && (frame_q.cnt < CW'(FW));
    assign force_hiz_o = frame_q.test && !en_ni && sdi_i;

    AST_HIZ_NOT_EARLY: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        force_hiz_o |-> (frame_q.cnt >= CW'(HIZ_EDGES)));                       // R6
    AST_CNT_CEILING: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        frame_q.cnt <= CW'(SAT));                                               // R8
    AST_LOW_SDI_EXITS: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        (!en_ni && !sdi_i) |=> !force_hiz_o);                                   // R7
endmodule

// File: rtl/scp_regs.sv
module scp_regs #(
    parameter int DW        = 8,
    parameter int AW        = 4,
    parameter int STAT_ADDR = 2,
    parameter int MASK_ADDR = 3,
    localparam int NREG = 1 << AW
) (
    input  logic          sclk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o,
    input  logic [DW-1:0] irq_src_i,
    output logic          irq_pull_o
);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam logic [AW-1:0] MASK_A = AW'(MASK_ADDR);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] mem;
        logic [DW-1:0]           pend;
    } regs_s;

    regs_s regs_d, regs_q;
    logic  clr;

    always_comb begin
        regs_d      = regs_q;
        clr         = rd_en_i && (raddr_i == STAT_A);
        regs_d.pend = (clr ? '0 : regs_q.pend) | irq_src_i;
        if (wr_en_i && (waddr_i != STAT_A)) begin
            regs_d.mem[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign rdata_o    = (raddr_i == STAT_A) ? regs_q.pend : regs_q.mem[raddr_i];
    assign irq_pull_o = |(regs_q.pend & regs_q.mem[MASK_A]);

    AST_WRITE_LANDS: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        (wr_en_i && (waddr_i != STAT_A)) |=> (regs_q.mem[$past(waddr_i)] == $past(wdata_i))); // R5
    AST_READ_CLEARS: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        (rd_en_i && (raddr_i == STAT_A) && (irq_src_i == '0)) |=> (regs_q.pend == '0));      // R10
    AST_STAT_WRITE_IGNORED: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        (wr_en_i && (waddr_i == STAT_A)) |=> (regs_q.pend == ($past(regs_q.pend) | $past(irq_src_i)))); // R11
endmodule

// File: rtl/scp_slave.sv
module scp_slave #(
    parameter int DW        = 8,
    parameter int AW        = 4,
    parameter int HIZ_EDGES = 33,
    parameter int STAT_ADDR = 2,
    parameter int MASK_ADDR = 3
) (
    input  logic          sclk_i,
    input  logic          rst_ni,
    input  logic          scp_en_ni,
    input  logic          sdi_i,
    input  logic [DW-1:0] irq_src_i,
    output logic          sdo_o,
    output logic          sdo_oe_o,
    output logic          force_hiz_o,
    output logic          irq_pull_o
);
    localparam int CW = $clog2(HIZ_EDGES + 2);

    typedef struct packed {
        logic          rd;
        logic [DW-1:0] tx;
    } tx_s;

    typedef struct packed {
        logic sdo;
        logic oe;
    } out_s;

    tx_s  tx_d, tx_q;
    out_s out_d, out_q;

    logic [CW-1:0] cnt;
    logic          rd_now, commit, tx_step;
    logic [AW-1:0] raddr, waddr;
    logic [DW-1:0] wdata, rdata;

    scp_frame #(.DW(DW), .AW(AW), .HIZ_EDGES(HIZ_EDGES)) u_frame (
        .sclk_i      (sclk_i),
        .rst_ni      (rst_ni),
        .en_ni       (scp_en_ni),
        .sdi_i       (sdi_i),
        .cnt_o       (cnt),
        .rd_now_o    (rd_now),
        .raddr_o     (raddr),
        .commit_o    (commit),
        .waddr_o     (waddr),
        .wdata_o     (wdata),
        .tx_step_o   (tx_step),
        .force_hiz_o (force_hiz_o)
    );

    scp_regs #(.DW(DW), .AW(AW), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)) u_regs (
        .sclk_i     (sclk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (commit),
        .waddr_i    (waddr),
        .wdata_i    (wdata),
        .rd_en_i    (rd_now),
        .raddr_i    (raddr),
        .rdata_o    (rdata),
        .irq_src_i  (irq_src_i),
        .irq_pull_o (irq_pull_o)
    );

    always_comb begin
        tx_d = tx_q;
        if (scp_en_ni) begin
            tx_d = '0;
        end else if (rd_now) begin
            tx_d.rd = 1'b1;
            tx_d.tx = rdata;
        end else if (tx_step) begin
            tx_d.tx = tx_q.tx << 1;
        end
        out_d.sdo = tx_q.tx[DW-1];
        out_d.oe  = tx_q.rd;
    end

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) tx_q <= '0;
        else         tx_q <= tx_d;
    end

    // Data-out changes on the falling edge
    always_ff @(negedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign sdo_o    = out_q.sdo;
    assign sdo_oe_o = out_q.oe && !scp_en_ni && !force_hiz_o;

    AST_OE_AFTER_CMD: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        sdo_oe_o |-> (cnt >= CW'(DW)));                                         // R3
endmodule

// File: tb/test_scp_slave.sv
module test_scp_slave;
    logic       sclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic       sdi = 1'b0;
    logic [7:0] src = 8'h00;
    logic       sdo, sdo_oe, force_hiz, irq_pull;

    int checks = 0;
    int fails  = 0;

    always #2 sclk = ~sclk;

    scp_slave i_scp_slave (
        .sclk_i      (sclk),
        .rst_ni      (rst_n),
        .scp_en_ni   (en_n),
        .sdi_i       (sdi),
        .irq_src_i   (src),
        .sdo_o       (sdo),
        .sdo_oe_o    (sdo_oe),
        .force_hiz_o (force_hiz),
        .irq_pull_o  (irq_pull)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    int         m_cnt;
    bit         m_allhi, m_test, m_rd, m_oe, m_sdo;
    logic [15:0] m_sh;
    logic [7:0]  m_tx, m_pend;
    logic [7:0]  m_reg [16];

    always @(posedge sclk) begin
        if (!rst_n) begin
            m_cnt = 0; m_allhi = 0; m_test = 0; m_rd = 0; m_sh = 0; m_tx = 0; m_pend = 0;
            foreach (m_reg[k]) m_reg[k] = 8'h00;
        end else begin
            automatic bit clr = 0;
            automatic logic [15:0] nsh;
            automatic int a;
            if (en_n) begin
                if (m_cnt == 16 && m_sh[15] == 1'b0) begin
                    a = int'(m_sh[14:11]);
                    if (a != 2) m_reg[a] = m_sh[7:0];
                end
                m_cnt = 0; m_allhi = 1; m_test = 0; m_rd = 0; m_tx = 0; m_sh = 0;
            end else begin
                if (m_cnt < 34) m_cnt++;
                nsh = {m_sh[14:0], sdi};
                m_allhi = m_allhi & sdi;
                m_test = m_allhi && (m_cnt >= 33);
                if (m_cnt == 8 && nsh[7]) begin
                    a = int'(nsh[6:3]);
                    m_rd = 1;
                    m_tx = (a == 2) ? m_pend : m_reg[a];
                    clr = (a == 2);
                end else if (m_cnt >= 9 && m_cnt <= 16) begin
                    m_tx = m_tx << 1;
                end
                m_sh = nsh;
            end
            m_pend = (clr ? 8'h00 : m_pend) | src;
        end
    end

    always @(negedge sclk) begin
        if (!rst_n) begin m_sdo = 0; m_oe = 0; end
        else begin m_sdo = m_tx[7]; m_oe = m_rd; end
    end

    // Per-cycle comparison against the model
    always @(negedge sclk) begin
        #1;
        if (rst_n) begin
            automatic bit e_force = m_test & ~en_n & sdi;
            automatic bit e_oe    = m_oe & ~en_n & ~e_force;
            automatic bit e_irq   = |(m_pend & m_reg[3]);
            check(force_hiz == e_force, "R6 R7 model float", force_hiz, e_force);
            check(sdo_oe == e_oe, "R3 R4 model oe", sdo_oe, e_oe);
            check(irq_pull == e_irq, "R9 model irq", irq_pull, e_irq);
            if (e_oe) check(sdo == m_sdo, "R3 model sdo", sdo, m_sdo);
        end
    end

    function automatic logic [15:0] word(input bit rd, input int a, input logic [7:0] d);
        logic [3:0] a4 = 4'(a);
        return {rd, a4, 3'b000, d};
    endfunction

    task automatic xfer(input logic [15:0] w, input int n, output logic [7:0] rd);
        rd = 8'h00;
        for (int i = 0; i < n; i++) begin
            @(negedge sclk);
            en_n = 1'b0;
            sdi = (i < 16) ? w[15-i] : 1'b0;
            #1;
            if (i >= 8 && i < 16) rd = {rd[6:0], sdo};
        end
        @(negedge sclk);
        en_n = 1'b1;
        sdi = 1'b0;
        @(negedge sclk);
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge sclk); src = v;
        @(negedge sclk); src = 8'h00;
        #1;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge sclk);
        #1;
        check(sdo_oe == 1'b0, "R1 oe in reset", sdo_oe, 0);
        check(force_hiz == 1'b0, "R1 float in reset", force_hiz, 0);
        check(irq_pull == 1'b0, "R1 irq in reset", irq_pull, 0);
        @(negedge sclk); rst_n = 1'b1;
        repeat (2) @(negedge sclk);

        xfer(word(1, 9, 8'h00), 16, r);
        check(r == 8'h00, "R1 register reset value", r, 8'h00);

        // R2 R5: write then read back, two patterns
        xfer(word(0, 5, 8'hA5), 16, r);
        xfer(word(1, 5, 8'h00), 16, r);
        check(r == 8'hA5, "R2 R5 readback reg5", r, 8'hA5);
        xfer(word(0, 12, 8'h3C), 16, r);
        xfer(word(1, 12, 8'hFF), 16, r);
        check(r == 8'h3C, "R2 R3 readback reg12", r, 8'h3C);

        // R5: wrong frame lengths store nothing
        xfer(word(0, 6, 8'h5A), 8, r);
        xfer(word(0, 7, 8'h81), 15, r);
        xfer(word(0, 7, 8'h81), 17, r);
        xfer(word(1, 6, 8'h00), 16, r);
        check(r == 8'h00, "R5 eight-edge write ignored", r, 8'h00);
        xfer(word(1, 7, 8'h00), 16, r);
        check(r == 8'h00, "R5 odd-length writes ignored", r, 8'h00);

        // R9 R10: interrupt pending and clear
        xfer(word(0, 3, 8'h0F), 16, r);
        pulse(8'h03);
        check(irq_pull == 1'b1, "R9 irq asserted", irq_pull, 1);
        xfer(word(1, 2, 8'h00), 16, r);
        check(r == 8'h03, "R10 status readback", r, 8'h03);
        #1;
        check(irq_pull == 1'b0, "R10 irq released", irq_pull, 0);
        pulse(8'h10);
        check(irq_pull == 1'b0, "R9 masked event", irq_pull, 0);
        xfer(word(1, 2, 8'h00), 16, r);
        check(r == 8'h10, "R10 masked bit pending", r, 8'h10);
        xfer(word(1, 2, 8'h00), 16, r);
        check(r == 8'h00, "R10 cleared by read", r, 8'h00);

        // R11: writing the status register has no effect
        xfer(word(0, 2, 8'hFF), 16, r);
        xfer(word(1, 2, 8'h00), 16, r);
        check(r == 8'h00, "R11 status write ignored", r, 8'h00);

        // R4: abort mid-read
        begin
            logic [15:0] w = word(1, 5, 8'h00);
            for (int i = 0; i < 12; i++) begin
                @(negedge sclk); en_n = 1'b0; sdi = w[15-i]; #1;
            end
            check(sdo_oe == 1'b1, "R3 driving mid-read", sdo_oe, 1);
            @(negedge sclk); en_n = 1'b1; sdi = 1'b0; #1;
            check(sdo_oe == 1'b0, "R4 immediate release", sdo_oe, 0);
            @(negedge sclk);
        end

        // R6 R7: test mode entry and exit on data-in low
        for (int i = 0; i < 40; i++) begin
            @(negedge sclk); en_n = 1'b0; sdi = 1'b1; #1;
            if (i == 32) check(force_hiz == 1'b0, "R6 not after 32 edges", force_hiz, 0);
            if (i == 33) check(force_hiz == 1'b1, "R6 entered after 33 edges", force_hiz, 1);
        end
        @(negedge sclk); sdi = 1'b0; #1;
        check(force_hiz == 1'b0, "R7 exit on data-in low", force_hiz, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge sclk); sdi = 1'b1; #1;
            check(force_hiz == 1'b0, "R7 no re-entry", force_hiz, 0);
        end
        @(negedge sclk); en_n = 1'b1; sdi = 1'b0;
        repeat (2) @(negedge sclk);

        // R8: long hold stays in test mode; R7 exit on select high
        for (int i = 0; i < 120; i++) begin
            @(negedge sclk); en_n = 1'b0; sdi = 1'b1; #1;
        end
        check(force_hiz == 1'b1, "R8 held after 120 edges", force_hiz, 1);
        @(negedge sclk); en_n = 1'b1; #1;
        check(force_hiz == 1'b0, "R7 exit on select high", force_hiz, 0);
        sdi = 1'b0;
        repeat (3) @(negedge sclk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule